// File: doc/BRIEF.md
# Bang-Bang Delay-Line Tap Controller

This block is the digital control loop of a delay-locked loop built from a chain of discrete delay steps. A flip-flop outside the block samples the reference clock at each edge of the delayed clock. The result is one early/late bit per comparison. The controller turns that stream of bits into a tap-select code for the delay line, so that the delayed edge settles onto the reference edge. Only the phase of the delayed clock is changed, never its frequency.

The detector gives only a fast/slow bit. It does not give an error magnitude, so the loop is of the bang-bang kind. To stop the code from chattering back and forth around the lock point, the decisions are fed into a signed vote counter that acts as a deadband. The tap code moves one step only when the net votes in one direction reach the programmed deadband. A wider deadband gives fewer corrections but allows a larger peak-to-peak phase error. The tap code stops at both ends of the delay line and never wraps around. A lock flag is raised once the code has stayed unchanged for a fixed number of decisions.

Top module: `dll_bang_ctrl`

## Requirements
- R1: After reset the tap code is the midpoint tap (16 with the default 5-bit code), the lock flag is low, and both the fast and slow indications are low.
- R2: A decision is a cycle with `enable` and `sampleValid` both high. One cycle after a decision, `lockedFast` equals the sampled bit and `lockedSlow` equals its inverse. A sampled bit of 1 means the delayed clock is fast, and 0 means it is slow. The two indications are never high together.
- R3: Each decision adds one vote: a fast decision counts +1 and a slow decision counts -1. When the vote total reaches +D, the tap code rises by one, which adds delay. When it reaches -D, the tap code falls by one, which removes delay. In both cases the vote total returns to zero. Opposite decisions cancel each other.
- R4: A deadband setting of 0 acts as a setting of 1, so every decision moves the tap code.
- R5: The tap code saturates at 0 and at its maximum (31 by default) and never wraps. If a vote reaches the threshold while the code is already at that end, the vote total still returns to zero and the code stays where it is.
- R6: While `enable` is low, decisions are ignored. The tap code, the vote total, the indications and the lock count all hold their values.
- R7: While `sampleValid` is low, the value of `sampleBit` has no effect on any output.
- R8: The lock flag goes high once 64 decisions have followed the last tap-code change without the code moving. Saturated attempts count as no change. The flag drops in the same cycle that the tap code changes.
- R9: The tap code changes by at most one step per clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Loop enable; when low the loop state is frozen |
| sampleValid | input | 1 | Marks the cycle that carries a new phase-detector sample |
| sampleBit | input | 1 | Reference clock sampled at the delayed edge: 1 = fast, 0 = slow |
| deadband | input | 4 | Net vote count needed before the tap code steps (0 treated as 1) |
| tapCode | output | 5 | Tap select for the discrete delay line; higher value means more delay |
| lockedFast | output | 1 | Last decision said the delayed clock is fast |
| lockedSlow | output | 1 | Last decision said the delayed clock is slow |
| lockFlag | output | 1 | Tap code has been stable for 64 decisions |

## Verification
Some properties are checked by assertions in every cycle. These are: the tap code moving at most one step, and rising only after a fast decision. The state holds while the loop is disabled or no sample is valid. The indications follow the last sampled bit and are never high together. The lock flag is low in any cycle in which the code has just moved, and the code does not wrap at the top end. Other behaviour needs the bench's scenarios to show it. This covers the vote counting up to the deadband and the cancelling of opposite votes, the handling of a zero deadband, and the vote clearing on a saturated attempt. It also covers the exact decision on which the lock flag rises after 64 unchanged decisions.

// File: rtl/dll_pkg.sv
package dll_pkg;

  // Strobes from the vote control to the tap datapath, valid for one cycle.
  typedef struct packed {
    logic decide;    // a qualified decision happened this cycle
    logic fastSeen;  // polarity of that decision (1 = delayed clock fast)
    logic stepUp;    // vote reached +deadband: ask for more delay
    logic stepDown;  // vote reached -deadband: ask for less delay
  } dllStrobes_t;

endpackage

// File: rtl/dll_vote_ctrl.sv
module dll_vote_ctrl
  import dll_pkg::*;
#(
  parameter int DB_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            sampleValid,
  input  logic            sampleBit,
  input  logic [DB_W-1:0] deadband,
  output dllStrobes_t     strobes
);

  localparam int VOTE_W = DB_W + 2;
  localparam logic signed [VOTE_W-1:0] VOTE_ONE = VOTE_W'(1);

  logic                     decide;
  logic [DB_W-1:0]          limitU;
  logic signed [VOTE_W-1:0] limitPos;
  logic signed [VOTE_W-1:0] limitNeg;
  logic signed [VOTE_W-1:0] vote;
  logic signed [VOTE_W-1:0] voteStep;
  logic signed [VOTE_W-1:0] voteNext;

  assign decide   = enable & sampleValid;
  // a zero deadband behaves like one vote
  assign limitU   = (deadband == '0) ? DB_W'(1) : deadband;
  assign limitPos = $signed({2'b00, limitU});
  assign limitNeg = -limitPos;
  assign voteStep = sampleBit ? (vote + VOTE_ONE) : (vote - VOTE_ONE);

  always_comb begin
    strobes  = '0;
    voteNext = vote;
    if (decide) begin
      strobes.decide   = 1'b1;
      strobes.fastSeen = sampleBit;
      if (voteStep >= limitPos) begin
        strobes.stepUp = 1'b1;
        voteNext       = '0;
      end else if (voteStep <= limitNeg) begin
        strobes.stepDown = 1'b1;
        voteNext         = '0;
      end else begin
        voteNext = voteStep;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vote <= '0;
    else       vote <= voteNext;
  end

endmodule

// File: rtl/dll_tap_path.sv
module dll_tap_path
  import dll_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int LOCK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  dllStrobes_t      strobes,
  output logic [TAP_W-1:0] tapCode,
  output logic             lockedFast,
  output logic             lockedSlow,
  output logic             lockFlag
);

  localparam logic [TAP_W-1:0] TAP_MAX  = '1;
  localparam logic [TAP_W-1:0] TAP_INIT = TAP_W'(1 << (TAP_W - 1));
  localparam int               LOCK_W   = $clog2(LOCK_CYCLES + 1);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCK_CYCLES);

  logic              moveUp;
  logic              moveDown;
  logic [TAP_W-1:0]  tapReg;
  logic [LOCK_W-1:0] lockCnt;
  logic              fastReg;
  logic              slowReg;

  // saturate at both ends of the line
  assign moveUp   = strobes.stepUp   & (tapReg != TAP_MAX);
  assign moveDown = strobes.stepDown & (tapReg != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapReg <= TAP_INIT;
    end else if (moveUp) begin
      tapReg <= tapReg + TAP_W'(1);
    end else if (moveDown) begin
      tapReg <= tapReg - TAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt <= '0;
    end else if (moveUp | moveDown) begin
      lockCnt <= '0;
    end else if (strobes.decide && (lockCnt != LOCK_END)) begin
      lockCnt <= lockCnt + LOCK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastReg <= 1'b0;
      slowReg <= 1'b0;
    end else if (strobes.decide) begin
      fastReg <= strobes.fastSeen;
      slowReg <= ~strobes.fastSeen;
    end
  end

  assign tapCode    = tapReg;
  assign lockedFast = fastReg;
  assign lockedSlow = slowReg;
  assign lockFlag   = (lockCnt == LOCK_END);

endmodule

// File: rtl/dll_bang_ctrl.sv
module dll_bang_ctrl
  import dll_pkg::*;
#(
  parameter int TAP_W       = 5,
  parameter int DB_W        = 4,
  parameter int LOCK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             sampleValid,
  input  logic             sampleBit,
  input  logic [DB_W-1:0]  deadband,
  output logic [TAP_W-1:0] tapCode,
  output logic             lockedFast,
  output logic             lockedSlow,
  output logic             lockFlag
);

  dllStrobes_t strobes;

  dll_vote_ctrl #(.DB_W(DB_W)) u_vote (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sampleValid (sampleValid),
    .sampleBit   (sampleBit),
    .deadband    (deadband),
    .strobes     (strobes)
  );

  dll_tap_path #(.TAP_W(TAP_W), .LOCK_CYCLES(LOCK_CYCLES)) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .tapCode    (tapCode),
    .lockedFast (lockedFast),
    .lockedSlow (lockedSlow),
    .lockFlag   (lockFlag)
  );

endmodule

// File: rtl/dll_bang_ctrl_chk.sv
module dll_bang_ctrl_chk #(
  parameter int TAP_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             sampleValid,
  input logic             sampleBit,
  input logic [TAP_W-1:0] tapCode,
  input logic             lockedFast,
  input logic             lockedSlow,
  input logic             lockFlag
);

  localparam logic [TAP_W-1:0] TAP_MAX = '1;

  // R9: one step at most, and no wrap at either end
  p_single_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tapCode == $past(tapCode)) ||
    ((tapCode == TAP_W'($past(tapCode) + 1'b1)) && ($past(tapCode) != TAP_MAX)) ||
    ((tapCode == TAP_W'($past(tapCode) - 1'b1)) && ($past(tapCode) != '0)));

  // R3: the code only rises after a fast decision
  p_rise_on_fast_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tapCode == TAP_W'($past(tapCode) + 1'b1)) |->
      $past(enable && sampleValid && sampleBit));

  // R5: a fast request at the top end keeps the code at the top
  p_top_saturate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (($past(tapCode) == TAP_MAX) && $past(enable && sampleValid && sampleBit)) |->
      (tapCode == TAP_MAX));

  // R6: frozen while disabled
  p_disabled_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(tapCode) && $stable(lockedFast) &&
                 $stable(lockedSlow) && $stable(lockFlag)));

  // R7: no sample, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(tapCode) && $stable(lockedFast) && $stable(lockedSlow)));

  // R2: indications follow the last decision
  p_indication_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enable && sampleValid) |=>
      ((lockedFast == $past(sampleBit)) && (lockedSlow == !$past(sampleBit))));

  p_indication_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lockedFast, lockedSlow}));

  // R8: lock is dropped whenever the code moves
  p_lock_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tapCode != $past(tapCode)) |-> !lockFlag);

endmodule

bind dll_bang_ctrl dll_bang_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .enable      (enable),
  .sampleValid (sampleValid),
  .sampleBit   (sampleBit),
  .tapCode     (tapCode),
  .lockedFast  (lockedFast),
  .lockedSlow  (lockedSlow),
  .lockFlag    (lockFlag)
);

// File: tb/dll_bang_ctrl_tb.sv
module dll_bang_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       sampleValid = 1'b0;
  logic       sampleBit = 1'b0;
  logic [3:0] deadband = 4'd3;
  logic [4:0] tapCode;
  logic       lockedFast;
  logic       lockedSlow;
  logic       lockFlag;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  dll_bang_ctrl u_dut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .sampleValid (sampleValid),
    .sampleBit   (sampleBit),
    .deadband    (deadband),
    .tapCode     (tapCode),
    .lockedFast  (lockedFast),
    .lockedSlow  (lockedSlow),
    .lockFlag    (lockFlag)
  );

  // vector: [15] polarity (1 = fast), [14:8] decision count, [7:0] tap expected after
  // deadband 3, starting at tap 16 with an empty vote
  localparam logic [15:0] VEC [0:6] = '{
    {1'b1, 7'd2, 8'd16},  // two fast votes: below threshold
    {1'b1, 7'd1, 8'd17},  // third fast vote steps up
    {1'b0, 7'd2, 8'd17},  // two slow votes pending
    {1'b1, 7'd2, 8'd17},  // cancelled by two fast
    {1'b0, 7'd3, 8'd16},  // three slow step down
    {1'b0, 7'd6, 8'd14},  // two more steps down
    {1'b1, 7'd3, 8'd15}   // one step up
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive n back-to-back decisions of one polarity; returns at a falling edge
  task automatic decide(input logic fast, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b1;
      sampleBit   = fast;
    end
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 tap", tapCode, 16);
    check("R1 lock", lockFlag, 0);
    check("R1 fast", lockedFast, 0);
    check("R1 slow", lockedSlow, 0);
    rstN   = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    // R3: vote accumulation and cancellation from the table
    for (int v = 0; v < 7; v++) begin
      decide(VEC[v][15], int'(VEC[v][14:8]));
      check($sformatf("R3 vector %0d tap", v), tapCode, int'(VEC[v][7:0]));
    end

    // R2: indications after fast then slow
    check("R2 fast after fast", lockedFast, 1);
    check("R2 slow after fast", lockedSlow, 0);
    decide(1'b0, 1);
    check("R2 slow after slow", lockedSlow, 1);
    check("R2 fast after slow", lockedFast, 0);
    check("R3 single slow below deadband", tapCode, 15);
    decide(1'b1, 1);  // vote back to zero

    // R4: zero deadband steps on every decision
    deadband = 4'd0;
    decide(1'b1, 1);
    check("R4 step up", tapCode, 16);
    decide(1'b0, 1);
    check("R4 step down", tapCode, 15);

    // R6: disabled loop ignores decisions
    enable = 1'b0;
    decide(1'b1, 5);
    check("R6 tap held", tapCode, 15);
    check("R6 slow held", lockedSlow, 1);
    check("R6 fast held", lockedFast, 0);
    enable = 1'b1;

    // R7: toggling sample bit without valid
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      sampleBit = ~sampleBit;
    end
    @(negedge clk);
    check("R7 tap held", tapCode, 15);
    check("R7 slow held", lockedSlow, 1);

    // R5: top saturation and vote clear
    deadband = 4'd1;
    decide(1'b1, 20);
    check("R5 top saturate", tapCode, 31);
    deadband = 4'd2;
    decide(1'b1, 2);
    check("R5 top held", tapCode, 31);
    decide(1'b0, 1);
    check("R5 vote cleared at top", tapCode, 31);
    decide(1'b0, 1);
    check("R5 step down from top", tapCode, 30);

    // R5: bottom saturation
    deadband = 4'd1;
    decide(1'b0, 35);
    check("R5 bottom saturate", tapCode, 0);

    // R8: lock timing
    decide(1'b1, 1);
    check("R8 moved off bottom", tapCode, 1);
    check("R8 lock low on move", lockFlag, 0);
    decide(1'b0, 1);
    check("R8 back to bottom", tapCode, 0);
    decide(1'b0, 63);
    check("R8 lock low after 63", lockFlag, 0);
    decide(1'b0, 1);
    check("R8 lock high after 64", lockFlag, 1);
    decide(1'b1, 1);
    check("R8 lock drops on move", lockFlag, 0);
    check("R8 tap after move", tapCode, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule